// File: doc/BRIEF.md
# Dual-Port Partitioned Coefficient ROM

This block is a read-only store of signed filter coefficients that feeds a multiply-accumulate datapath. The coefficient table is organised as many small sets of thirteen coefficients each. The whole table sits in one flat, uniformly wide memory. Each word is found by a linear address: the global set number fills the upper bits and the coefficient position fills the lowest four bits.

Two read ports run fully independently, and both can read in the same cycle. Each port acts as a separate ROM over its own half of the memory. Port A sees the lower half of the sets, and port B sees the upper half through a fixed offset. On a port, the caller presents a local set number, a coefficient index and a read enable. One clock later the port returns the coefficient and a valid flag. The contents are computed at elaboration by a deterministic function of the set and the index, so no memory file is needed. The single internal write path is tied off permanently.

Top module: `coef_rom_top`

## Requirements
- R1: While reset is asserted and right after it is released, `a_valid` and `b_valid` are 0 and `a_data` and `b_data` are 0.
- R2: Each stored word is an 18-bit two's-complement value. For global set g < 180 and index k < 13, the value is ((17 + 3109·g + 7919·k + 211·(g XOR k)) mod 262144) − 131072. Reading the same address again returns the same value.
- R3: A port's valid output is high in exactly the cycle after a cycle in which that port's read enable was high. Each enabled read produces exactly one valid result.
- R4: For a local set s with 0 ≤ s ≤ 89, port A returns the word of global set s. Its address stays in the lower half of the memory.
- R5: For a local set s with 0 ≤ s ≤ 89, port B returns the word of global set 90 + s. Its address stays in the upper half of the memory.
- R6: Coefficient indices 13, 14 and 15 read as zero on both ports.
- R7: A local set number of 90 or above (up to 127, since the field is 7 bits) reads as zero on either port.
- R8: While a port's read enable is low, its data output keeps its previous value.
- R9: Both ports can be enabled in the same cycle with different addresses. Each port returns its own correct word, and neither port affects the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_rd_en | input | 1 | Port A read enable |
| a_set | input | 7 | Port A local set number (global set = local) |
| a_idx | input | 4 | Port A coefficient index |
| a_data | output | 18 | Port A signed coefficient |
| a_valid | output | 1 | Port A result valid |
| b_rd_en | input | 1 | Port B read enable |
| b_set | input | 7 | Port B local set number (global set = local + 90) |
| b_idx | input | 4 | Port B coefficient index |
| b_data | output | 18 | Port B signed coefficient |
| b_valid | output | 1 | Port B result valid |

## Verification
Every result on either port is due exactly one rising edge after its read enable was sampled. The driver applies a request at a falling edge and pushes the independently computed expected word into that port's queue. The monitor looks at the outputs at the next falling edge, which is half a period after the edge that produced them. A valid without a queued entry, or an entry left in the queue at the end, shows a latency fault. On a falling edge where valid is low, the monitor checks that the data still equals the last word delivered.

// File: rtl/coef_rom_pkg.sv
package coef_rom_pkg;

  // Deterministic coefficient generator: value of coefficient idx_i in
  // global set set_i, centred into a coef_w-bit signed range.
  function automatic int coef_word(int set_i, int idx_i, int per_set,
                                   int n_sets, int coef_w);
    int mix;
    int span;
    if (idx_i >= per_set || set_i < 0 || set_i >= n_sets) return 0;
    span = 1 << coef_w;
    mix  = set_i * 3109 + idx_i * 7919 + (set_i ^ idx_i) * 211 + 17;
    return (mix % span) - (span / 2);
  endfunction

  // Linear word address: set in the high bits, index in the low idx_w bits.
  function automatic int lin_addr(int set_i, int idx_i, int idx_w);
    return (set_i << idx_w) + idx_i;
  endfunction

endpackage

// File: rtl/coef_port_map.sv
module coef_port_map
  import coef_rom_pkg::*;
#(
  parameter int LSET_W    = 7,
  parameter int IDX_W     = 4,
  parameter int ADDR_W    = 12,
  parameter int BASE_SET  = 0,
  parameter int SPAN_SETS = 90
) (
  input  logic [LSET_W-1:0] lset,
  input  logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] addr,
  output logic              in_range
);

  always_comb begin
    in_range = (int'(lset) < SPAN_SETS);
    if (in_range)
      addr = ADDR_W'(lin_addr(BASE_SET + int'(lset), int'(idx), IDX_W));
    else
      addr = '0;
  end

endmodule

// File: rtl/coef_rom_store.sv
module coef_rom_store
  import coef_rom_pkg::*;
#(
  parameter int COEF_W   = 18,
  parameter int PER_SET  = 13,
  parameter int NUM_SETS = 180,
  parameter int IDX_W    = 4,
  parameter int NPORT    = 2,
  localparam int DEPTH   = NUM_SETS << IDX_W,
  localparam int ADDR_W  = $clog2(DEPTH)
) (
  input  logic                         clk,
  input  logic [NPORT-1:0]             rd_en,
  input  logic [NPORT-1:0][ADDR_W-1:0] rd_addr,
  output logic [NPORT-1:0][COEF_W-1:0] rd_q,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [COEF_W-1:0]            wr_data
);

  localparam int IDX_MASK = (1 << IDX_W) - 1;

  logic [COEF_W-1:0] mem [DEPTH];

  // Contents computed at elaboration.
  initial begin
    for (int a = 0; a < DEPTH; a++)
      mem[a] = COEF_W'(coef_word(a >> IDX_W, a & IDX_MASK, PER_SET,
                                 NUM_SETS, COEF_W));
  end

  // Write side of the dual-port structure; its enable is tied low above.
  always @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    for (int p = 0; p < NPORT; p++)
      if (rd_en[p]) rd_q[p] <= mem[rd_addr[p]];
  end

endmodule

// File: rtl/coef_read_stage.sv
module coef_read_stage #(
  parameter int COEF_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              in_range,
  input  logic [COEF_W-1:0] mem_q,
  output logic [COEF_W-1:0] data,
  output logic              valid,
  output logic              hit_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_q <= 1'b0;
      valid <= 1'b0;
    end else begin
      valid <= rd_en;
      if (rd_en) hit_q <= in_range;
    end
  end

  assign data = hit_q ? mem_q : '0;

endmodule

// File: rtl/coef_rom_top.sv
module coef_rom_top #(
  parameter int COEF_W        = 18,
  parameter int COEFS_PER_SET = 13,
  parameter int NUM_SETS      = 180,
  parameter int IDX_W         = 4,
  localparam int HALF_SETS    = NUM_SETS / 2,
  localparam int LSET_W       = $clog2(HALF_SETS),
  localparam int DEPTH        = NUM_SETS << IDX_W,
  localparam int ADDR_W       = $clog2(DEPTH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     a_rd_en,
  input  logic [LSET_W-1:0]        a_set,
  input  logic [IDX_W-1:0]         a_idx,
  output logic signed [COEF_W-1:0] a_data,
  output logic                     a_valid,
  input  logic                     b_rd_en,
  input  logic [LSET_W-1:0]        b_set,
  input  logic [IDX_W-1:0]         b_idx,
  output logic signed [COEF_W-1:0] b_data,
  output logic                     b_valid
);

  localparam int NPORT = 2;

  logic [NPORT-1:0]             rd_en;
  logic [NPORT-1:0][LSET_W-1:0] lset;
  logic [NPORT-1:0][IDX_W-1:0]  idx;
  logic [NPORT-1:0][ADDR_W-1:0] map_addr;
  logic [NPORT-1:0]             map_hit;
  logic [NPORT-1:0][COEF_W-1:0] mem_q;
  logic [NPORT-1:0][COEF_W-1:0] out_data;
  logic [NPORT-1:0]             out_valid;
  logic [NPORT-1:0]             out_hit;

  assign rd_en = {b_rd_en, a_rd_en};
  assign lset  = {b_set, a_set};
  assign idx   = {b_idx, a_idx};

  // Named observation wires for the checker.
  logic [ADDR_W-1:0] a_map_addr, b_map_addr;
  logic              a_map_hit, b_map_hit;
  assign a_map_addr = map_addr[0];
  assign b_map_addr = map_addr[1];
  assign a_map_hit  = map_hit[0] & a_rd_en;
  assign b_map_hit  = map_hit[1] & b_rd_en;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    coef_port_map #(
      .LSET_W(LSET_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W),
      .BASE_SET(p * HALF_SETS), .SPAN_SETS(HALF_SETS)
    ) u_map (
      .lset(lset[p]), .idx(idx[p]),
      .addr(map_addr[p]), .in_range(map_hit[p])
    );

    coef_read_stage #(.COEF_W(COEF_W)) u_stage (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en[p]), .in_range(map_hit[p]),
      .mem_q(mem_q[p]), .data(out_data[p]), .valid(out_valid[p]),
      .hit_q(out_hit[p])
    );
  end

  coef_rom_store #(
    .COEF_W(COEF_W), .PER_SET(COEFS_PER_SET), .NUM_SETS(NUM_SETS),
    .IDX_W(IDX_W), .NPORT(NPORT)
  ) u_store (
    .clk(clk), .rd_en(rd_en), .rd_addr(map_addr), .rd_q(mem_q),
    .wr_en(1'b0), .wr_addr('0), .wr_data('0)
  );

  assign a_data  = out_data[0];
  assign b_data  = out_data[1];
  assign a_valid = out_valid[0];
  assign b_valid = out_valid[1];

endmodule

// File: rtl/coef_rom_chk.sv
module coef_rom_chk #(
  parameter int COEF_W        = 18,
  parameter int COEFS_PER_SET = 13,
  parameter int HALF_SETS     = 90,
  parameter int IDX_W         = 4,
  parameter int LSET_W        = 7,
  parameter int ADDR_W        = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              a_rd_en,
  input logic [LSET_W-1:0] a_set,
  input logic [IDX_W-1:0]  a_idx,
  input logic [COEF_W-1:0] a_data,
  input logic              a_valid,
  input logic              b_rd_en,
  input logic [LSET_W-1:0] b_set,
  input logic [IDX_W-1:0]  b_idx,
  input logic [COEF_W-1:0] b_data,
  input logic              b_valid,
  input logic [ADDR_W-1:0] a_map_addr,
  input logic [ADDR_W-1:0] b_map_addr,
  input logic              a_map_hit,
  input logic              b_map_hit
);

  localparam int SPLIT = HALF_SETS << IDX_W;

  a_r3_a_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    a_rd_en |=> a_valid);
  a_r3_a_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !a_rd_en |=> !a_valid);
  a_r3_b_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    b_rd_en |=> b_valid);
  a_r3_b_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !b_rd_en |=> !b_valid);

  a_r4_a_lower_half: assert property (@(posedge clk) disable iff (!rst_n)
    a_map_hit |-> (int'(a_map_addr) < SPLIT));
  a_r5_b_upper_half: assert property (@(posedge clk) disable iff (!rst_n)
    b_map_hit |-> (int'(b_map_addr) >= SPLIT));

  a_r6_a_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (a_rd_en && int'(a_idx) >= COEFS_PER_SET) |=> (a_data == '0));
  a_r6_b_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (b_rd_en && int'(b_idx) >= COEFS_PER_SET) |=> (b_data == '0));

  a_r7_a_range_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (a_rd_en && int'(a_set) >= HALF_SETS) |=> (a_data == '0));
  a_r7_b_range_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (b_rd_en && int'(b_set) >= HALF_SETS) |=> (b_data == '0));

  a_r8_a_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !a_rd_en |=> $stable(a_data));
  a_r8_b_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !b_rd_en |=> $stable(b_data));

endmodule

bind coef_rom_top coef_rom_chk #(
  .COEF_W(COEF_W), .COEFS_PER_SET(COEFS_PER_SET), .HALF_SETS(HALF_SETS),
  .IDX_W(IDX_W), .LSET_W(LSET_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .a_rd_en(a_rd_en), .a_set(a_set), .a_idx(a_idx), .a_data(a_data),
  .a_valid(a_valid),
  .b_rd_en(b_rd_en), .b_set(b_set), .b_idx(b_idx), .b_data(b_data),
  .b_valid(b_valid),
  .a_map_addr(a_map_addr), .b_map_addr(b_map_addr),
  .a_map_hit(a_map_hit), .b_map_hit(b_map_hit)
);

// File: tb/coef_rom_top_tb.sv
module coef_rom_top_tb;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 90;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              a_rd_en = 1'b0, b_rd_en = 1'b0;
  logic [6:0]        a_set = '0, b_set = '0;
  logic [3:0]        a_idx = '0, b_idx = '0;
  logic signed [17:0] a_data, b_data;
  logic              a_valid, b_valid;

  int    checks = 0;
  int    errors = 0;
  int    qa[$], qb[$];
  string ta[$], tb_q[$];
  int    last_a = 0, last_b = 0;
  bit    mon_on = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  coef_rom_top u_dut (
    .clk(clk), .rst_n(rst_n),
    .a_rd_en(a_rd_en), .a_set(a_set), .a_idx(a_idx),
    .a_data(a_data), .a_valid(a_valid),
    .b_rd_en(b_rd_en), .b_set(b_set), .b_idx(b_idx),
    .b_data(b_data), .b_valid(b_valid)
  );

  // Reference word restated from R2, written independently.
  function automatic int ref_coef(int g, int k);
    int m, r;
    if (k > 12 || g > 179) return 0;
    m = 17 + 3109 * g + 7919 * k + 211 * (g ^ k);
    r = m - (m / 262144) * 262144;
    return r - 131072;
  endfunction

  function automatic string tag_for(int s, int k, string dflt);
    if (s >= HALF) return "R7";
    if (k >= 13)   return "R6";
    return dflt;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Driver: applies one cycle of requests and queues the expected words.
  task automatic drive(bit ae, int as, int ai, bit be, int bs, int bi,
                       string tag_a = "R4", string tag_b = "R5");
    @(negedge clk);
    a_rd_en = ae; a_set = 7'(as); a_idx = 4'(ai);
    b_rd_en = be; b_set = 7'(bs); b_idx = 4'(bi);
    if (ae) begin
      qa.push_back(as >= HALF ? 0 : ref_coef(as, ai));
      ta.push_back(tag_for(as, ai, tag_a));
    end
    if (be) begin
      qb.push_back(bs >= HALF ? 0 : ref_coef(HALF + bs, bi));
      tb_q.push_back(tag_for(bs, bi, tag_b));
    end
  endtask

  // Monitor: results due one edge after the request, sampled at negedge.
  always @(negedge clk) begin
    if (mon_on) begin
      if (a_valid) begin
        if (qa.size() == 0) check(1'b0, "R3 port A extra valid", 1, 0);
        else begin
          int e;
          string t;
          e = qa.pop_front(); t = ta.pop_front();
          check(int'(a_data) == e, t, int'(a_data), e);
          last_a = e;
        end
      end else
        check(int'(a_data) == last_a, "R8 port A hold", int'(a_data), last_a);
      if (b_valid) begin
        if (qb.size() == 0) check(1'b0, "R3 port B extra valid", 1, 0);
        else begin
          int e;
          string t;
          e = qb.pop_front(); t = tb_q.pop_front();
          check(int'(b_data) == e, t, int'(b_data), e);
          last_b = e;
        end
      end else
        check(int'(b_data) == last_b, "R8 port B hold", int'(b_data), last_b);
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL R3 watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs quiet during reset
    check(!a_valid && !b_valid, "R1 valid in reset", int'(a_valid) + int'(b_valid), 0);
    check(a_data == 0 && b_data == 0, "R1 data in reset", int'(a_data) | int'(b_data), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!a_valid && !b_valid, "R1 valid after release", int'(a_valid) + int'(b_valid), 0);
    check(a_data == 0 && b_data == 0, "R1 data after release", int'(a_data) | int'(b_data), 0);
    mon_on = 1'b1;

    // R9: both ports read different sets in the same cycle, full sweep.
    for (int s = 0; s < HALF; s++)
      for (int k = 0; k < 16; k++)
        drive(1, s, k, 1, HALF - 1 - s, 15 - k, "R4 R9", "R5 R9");

    // R7: local sets past the half, with edges 88/89 still in range.
    for (int s = 88; s < 128; s++)
      drive(1, s, s % 16, 1, 215 - s, 3);

    // R8: gaps and single-port activity.
    drive(1, 5, 2, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 0);
    drive(0, 9, 9, 1, 40, 11);
    drive(0, 0, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 0);

    // R2: repeated reads of the same addresses return identical words.
    drive(1, 7, 7, 1, 7, 7, "R2", "R2");
    drive(0, 0, 0, 0, 0, 0);
    drive(1, 7, 7, 1, 7, 7, "R2", "R2");
    drive(1, 0, 0, 1, 0, 0, "R2", "R2");
    drive(1, 89, 12, 1, 89, 12, "R2", "R2");

    // R3: isolated read, valid for one cycle only.
    drive(0, 0, 0, 0, 0, 0);
    drive(1, 30, 4, 0, 0, 0, "R3", "R3");
    drive(0, 0, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 0);
    @(negedge clk);
    mon_on = 1'b0;
    check(qa.size() == 0, "R3 port A pending", qa.size(), 0);
    check(qb.size() == 0, "R3 port B pending", qb.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule